// File: doc/BRIEF.md
# SPI Parallel-Load Input Serializer

This block is the serial front end of an eight-channel digital input module. An SPI master reads it with 16-bit frames. When the active-low chip select falls, the block takes one snapshot into a single 16-bit shift register. The eight channel states go into the upper byte and eight control/status bits from a port go into the lower byte. The block then sends that word out on MISO, most significant bit first, in SPI mode 0. At the same time, each bit sampled from MOSI enters at the low end of the register. Several of these blocks can therefore be wired in a chain, with one block's MISO feeding the next block's MOSI.

All SPI pins are asynchronous to the system clock. They pass through multi-flop synchronisers, and edges are found from the synchronised samples. The system clock must run at least four times faster than SCK. When chip select rises, the block reports the word received from MOSI with a one-cycle strobe if the frame held exactly one word of SCK rising edges. Otherwise it raises a framing-error flag.

Top module: `spi_din_serializer`

## Requirements
- R1: While chip select is high, MISO is high impedance, and SCK and MOSI activity changes neither MISO, the strobe nor the error flag.
- R2: A chip-select falling edge loads `din` into word bits [15:8] (channel k at bit 8+k, so channel 7 is the MSB) and `ctl` into bits [7:0].
- R3: MOSI is sampled on each SCK rising edge and enters at bit 0 while the register shifts toward bit 15 (mode 0, MSB first).
- R4: The loaded MSB is driven on MISO as soon as chip select falls. Each following bit appears after an SCK falling edge.
- R5: After 16 SCK cycles, the MOSI bits come back out on MISO in the order they were received (chain mode).
- R6: When chip select rises after exactly 16 SCK rising edges, `rx_word` holds the 16 MOSI bits (first bit at bit 15) and `rx_valid` is high for exactly one clock.
- R7: When chip select rises after any other number of SCK rising edges, `rx_valid` stays low and `frame_err` goes high. The flag is held until the next chip-select falling edge clears it.
- R8: Every SPI input takes effect on the third rising system-clock edge after it changes: two synchroniser flops plus one register.
- R9: A synchronous active-high reset clears the register, bit count, strobe and flag, and leaves MISO high impedance.
- R10: Changes on `din` and `ctl` after the chip-select falling edge do not alter the word being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Channel logic states |
| ctl | input | 8 | Control/status bits for the low byte |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, high impedance when deselected |
| spi_miso_oe | output | 1 | MISO driver enable |
| rx_word | output | 16 | Word received from MOSI |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| frame_err | output | 1 | Wrong SCK count in last frame |

## Verification
The assertions assume that chip select changes only while SCK is low. They also assume that each SCK level lasts at least two system clocks, so no synchronised edge is lost and the mode-0 sequence of a rising edge first holds. The bench meets both conditions. It drives every pin on the falling system-clock edge and holds each SCK phase for four clocks. It changes chip select and MOSI only in the SCK-low phase, and it toggles SCK while deselected only as a burst, with chip select held high throughout.

// File: rtl/spi_din_pkg.sv
package spi_din_pkg;

   // Synchronised SPI events, one system clock wide each
   typedef struct packed {
      logic sel_fall;   // chip select asserted
      logic sel_rise;   // chip select released
      logic clk_rise;   // SCK rising while selected
      logic clk_fall;   // SCK falling while selected
      logic selected;   // chip select low (synchronised)
   } spi_evt_t;

   function automatic int cnt_width(input int word_w);
      return $clog2(word_w) + 2;
   endfunction

endpackage

// File: rtl/spi_din_sync.sv
module spi_din_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_din_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) pipe[0] <= RST_VAL;
            else     pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) pipe[s] <= RST_VAL;
            else     pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_din_edge.sv
module spi_din_edge
   import spi_din_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     sck_s,
   input  logic     cs_n_s,
   output spi_evt_t evt
);

   logic sck_d;
   logic cs_n_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         sck_d  <= 1'b0;
         cs_n_d <= 1'b1;
      end else begin
         sck_d  <= sck_s;
         cs_n_d <= cs_n_s;
      end
   end

   always_comb begin
      evt          = '0;
      evt.selected = ~cs_n_s;
      evt.sel_fall = cs_n_d & ~cs_n_s;
      evt.sel_rise = ~cs_n_d & cs_n_s;
      evt.clk_rise = ~cs_n_s & ~sck_d & sck_s;
      evt.clk_fall = ~cs_n_s & sck_d & ~sck_s;
   end

endmodule

// File: rtl/spi_din_shreg.sv
module spi_din_shreg
   import spi_din_pkg::*;
#(
   parameter int IN_W   = 8,
   parameter int CTL_W  = 8,
   parameter int WORD_W = IN_W + CTL_W
) (
   input  logic              clk,
   input  logic              rst,
   input  spi_evt_t          evt,
   input  logic              mosi_s,
   input  logic [IN_W-1:0]   din,
   input  logic [CTL_W-1:0]  ctl,
   output logic [WORD_W-1:0] sreg,
   output logic              miso_d,
   output logic              miso_oe
);

   if (WORD_W != IN_W + CTL_W) begin : g_bad_word
      $error("spi_din_shreg: WORD_W must equal IN_W + CTL_W");
   end

   logic [WORD_W-1:0] load_word;
   assign load_word = {din, ctl};

   // Capture on SCK rise, MSB-first, new bit at the LSB end
   always_ff @(posedge clk) begin
      if (rst) begin
         sreg <= '0;
      end else if (evt.sel_fall) begin
         sreg <= load_word;
      end else if (evt.clk_rise) begin
         sreg <= {sreg[WORD_W-2:0], mosi_s};
      end
   end

   // Output bit: MSB at select, then the next MSB after each SCK fall
   always_ff @(posedge clk) begin
      if (rst) begin
         miso_d  <= 1'b0;
         miso_oe <= 1'b0;
      end else begin
         if (evt.sel_fall) begin
            miso_d  <= load_word[WORD_W-1];
            miso_oe <= 1'b1;
         end else if (evt.clk_fall) begin
            miso_d  <= sreg[WORD_W-1];
         end
         if (evt.sel_rise) miso_oe <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_din_frame.sv
module spi_din_frame
   import spi_din_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CNT_W  = cnt_width(WORD_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  spi_evt_t          evt,
   input  logic [WORD_W-1:0] sreg,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              frame_err
);

   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

   if ((1 << CNT_W) <= WORD_W + 1) begin : g_bad_cnt
      $error("spi_din_frame: CNT_W too narrow for WORD_W");
   end

   // Saturating count of SCK rising edges in the frame
   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt <= '0;
      end else if (evt.sel_fall) begin
         bit_cnt <= '0;
      end else if (evt.clk_rise && bit_cnt != CNT_MAX) begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_word   <= '0;
         rx_valid  <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (evt.sel_fall) begin
            frame_err <= 1'b0;
         end else if (evt.sel_rise) begin
            if (bit_cnt == CNT_WORD) begin
               rx_word  <= sreg;
               rx_valid <= 1'b1;
            end else begin
               frame_err <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_din_serializer.sv
module spi_din_serializer
   import spi_din_pkg::*;
#(
   parameter int IN_W        = 8,
   parameter int CTL_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [IN_W-1:0]        din,
   input  logic [CTL_W-1:0]       ctl,
   input  logic                   spi_sck,
   input  logic                   spi_cs_n,
   input  logic                   spi_mosi,
   output logic                   spi_miso,
   output logic                   spi_miso_oe,
   output logic [IN_W+CTL_W-1:0]  rx_word,
   output logic                   rx_valid,
   output logic                   frame_err
);

   localparam int WORD_W = IN_W + CTL_W;
   localparam int CNT_W  = cnt_width(WORD_W);

   if (IN_W < 1 || CTL_W < 1) begin : g_bad_width
      $error("spi_din_serializer: IN_W and CTL_W must be positive");
   end

   // Pin order in the synchroniser bus: {sck, cs_n, mosi}
   logic [2:0] pins_s;
   logic       sck_s;
   logic       cs_n_s;
   logic       mosi_s;

   spi_din_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({spi_sck, spi_cs_n, spi_mosi}),
      .q   (pins_s)
   );

   assign sck_s  = pins_s[2];
   assign cs_n_s = pins_s[1];
   assign mosi_s = pins_s[0];

   spi_evt_t evt;

   spi_din_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .sck_s  (sck_s),
      .cs_n_s (cs_n_s),
      .evt    (evt)
   );

   logic [WORD_W-1:0] sreg;
   logic              miso_d;

   spi_din_shreg #(
      .IN_W   (IN_W),
      .CTL_W  (CTL_W),
      .WORD_W (WORD_W)
   ) u_shreg (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt),
      .mosi_s  (mosi_s),
      .din     (din),
      .ctl     (ctl),
      .sreg    (sreg),
      .miso_d  (miso_d),
      .miso_oe (spi_miso_oe)
   );

   logic [CNT_W-1:0] bit_cnt;

   spi_din_frame #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) u_frame (
      .clk       (clk),
      .rst       (rst),
      .evt       (evt),
      .sreg      (sreg),
      .bit_cnt   (bit_cnt),
      .rx_word   (rx_word),
      .rx_valid  (rx_valid),
      .frame_err (frame_err)
   );

   assign spi_miso = spi_miso_oe ? miso_d : 1'bz;

endmodule

// File: rtl/spi_din_serializer_chk.sv
module spi_din_serializer_chk
   import spi_din_pkg::*;
#(
   parameter int IN_W   = 8,
   parameter int CTL_W  = 8,
   parameter int WORD_W = IN_W + CTL_W,
   parameter int CNT_W  = cnt_width(WORD_W)
) (
   input logic              clk,
   input logic              rst,
   input logic [IN_W-1:0]   din,
   input logic [CTL_W-1:0]  ctl,
   input spi_evt_t          evt,
   input logic              mosi_s,
   input logic [WORD_W-1:0] sreg,
   input logic              miso_d,
   input logic              spi_miso_oe,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              rx_valid,
   input logic              frame_err
);

   // Deselected: no output drive after release
   p_release_hiz_r1: assert property (@(posedge clk) disable iff (rst)
      evt.sel_rise |=> !spi_miso_oe);

   // Deselected and idle: register and flags hold
   p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (!evt.selected && !evt.sel_rise) |=> ($stable(sreg) && !rx_valid && $stable(frame_err)));

   // Parallel load of channels and control byte
   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      evt.sel_fall |=> (sreg == {$past(din), $past(ctl)}));

   // MOSI enters at the LSB on SCK rise
   p_capture_r3: assert property (@(posedge clk) disable iff (rst)
      evt.clk_rise |=> (sreg[0] == $past(mosi_s)));

   // First MISO bit is the loaded MSB, driven at once
   p_first_bit_r4: assert property (@(posedge clk) disable iff (rst)
      evt.sel_fall |=> (spi_miso_oe && miso_d == $past(din[IN_W-1])));

   // MISO only moves on select or SCK fall
   p_miso_timing_r4: assert property (@(posedge clk) disable iff (rst)
      (!evt.sel_fall && !evt.clk_fall) |=> $stable(miso_d));

   // Strobe only after a full word, and only for one cycle
   p_valid_count_r6: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> ($past(evt.sel_rise) && $past(bit_cnt) == CNT_W'(WORD_W)));

   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   // Wrong count flags an error and suppresses the strobe
   p_frame_err_r7: assert property (@(posedge clk) disable iff (rst)
      (evt.sel_rise && bit_cnt != CNT_W'(WORD_W)) |=> (frame_err && !rx_valid));

   // Reset state
   p_reset_r9: assert property (@(posedge clk)
      rst |=> (!spi_miso_oe && !rx_valid && !frame_err && sreg == '0 && bit_cnt == '0));

endmodule

bind spi_din_serializer spi_din_serializer_chk #(
   .IN_W  (IN_W),
   .CTL_W (CTL_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .din         (din),
   .ctl         (ctl),
   .evt         (evt),
   .mosi_s      (mosi_s),
   .sreg        (sreg),
   .miso_d      (miso_d),
   .spi_miso_oe (spi_miso_oe),
   .bit_cnt     (bit_cnt),
   .rx_valid    (rx_valid),
   .frame_err   (frame_err)
);

// File: tb/spi_din_serializer_test.sv
module spi_din_serializer_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  din = '0;
   logic [7:0]  ctl = '0;
   logic        spi_sck = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   wire         spi_miso;
   logic        spi_miso_oe;
   logic [15:0] rx_word;
   logic        rx_valid;
   logic        frame_err;

   int tests = 0;
   int fails = 0;
   int nvalid = 0;
   logic [15:0] last_word = '0;
   bit done = 0;

   always #5 clk = ~clk;

   spi_din_serializer uut (
      .clk         (clk),
      .rst         (rst),
      .din         (din),
      .ctl         (ctl),
      .spi_sck     (spi_sck),
      .spi_cs_n    (spi_cs_n),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_oe (spi_miso_oe),
      .rx_word     (rx_word),
      .rx_valid    (rx_valid),
      .frame_err   (frame_err)
   );

   always @(negedge clk) begin
      if (rx_valid) begin
         nvalid    <= nvalid + 1;
         last_word <= rx_word;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Send nbits of tx MSB first; got collects MISO before each SCK rise
   task automatic frame(input logic [31:0] tx, input int nbits,
                        input logic [7:0] d, input logic [7:0] c,
                        output logic [31:0] got);
      got = '0;
      din = d;
      ctl = c;
      wait_n(1);
      spi_cs_n = 1'b0;
      wait_n(4);
      for (int i = nbits - 1; i >= 0; i--) begin
         spi_mosi = tx[i];
         wait_n(4);
         got = {got[30:0], spi_miso};
         spi_sck = 1'b1;
         wait_n(4);
         spi_sck = 1'b0;
      end
      wait_n(4);
      spi_cs_n = 1'b1;
      wait_n(6);
   endtask

   task automatic t_reset;
      check("R9 miso hiz", {31'd0, spi_miso}, {31'd0, 1'bz});
      check("R9 oe", {31'd0, spi_miso_oe}, 32'd0);
      check("R9 valid", {31'd0, rx_valid}, 32'd0);
      check("R9 err", {31'd0, frame_err}, 32'd0);
   endtask

   task automatic t_latency;
      din = 8'h80;
      wait_n(1);
      spi_cs_n = 1'b0;
      wait_n(2);
      check("R8 two edges still hiz", {31'd0, spi_miso_oe}, 32'd0);
      wait_n(1);
      check("R8 third edge drives", {31'd0, spi_miso_oe}, 32'd1);
      check("R4 MSB at select", {31'd0, spi_miso}, 32'd1);
      spi_cs_n = 1'b1;
      wait_n(4);
      check("R1 released hiz", {31'd0, spi_miso}, {31'd0, 1'bz});
      check("R7 zero-bit frame err", {31'd0, frame_err}, 32'd1);
   endtask

   task automatic t_word(input logic [15:0] tx, input logic [7:0] d, input logic [7:0] c);
      logic [31:0] got;
      int v0;
      v0 = nvalid;
      frame({16'd0, tx}, 16, d, c, got);
      check("R2 R4 miso word", {16'd0, got[15:0]}, {16'd0, d, c});
      check("R6 one strobe", nvalid - v0, 32'd1);
      check("R3 R6 rx_word", {16'd0, last_word}, {16'd0, tx});
      check("R6 no err", {31'd0, frame_err}, 32'd0);
      check("R1 hiz after", {31'd0, spi_miso}, {31'd0, 1'bz});
   endtask

   task automatic t_din_change;
      logic [31:0] got;
      got = '0;
      din = 8'h3C;
      ctl = 8'h81;
      wait_n(1);
      spi_cs_n = 1'b0;
      wait_n(4);
      for (int i = 15; i >= 0; i--) begin
         spi_mosi = i[0];
         if (i == 12) begin
            din = 8'hFF;
            ctl = 8'h00;
         end
         wait_n(4);
         got = {got[30:0], spi_miso};
         spi_sck = 1'b1;
         wait_n(4);
         spi_sck = 1'b0;
      end
      wait_n(4);
      spi_cs_n = 1'b1;
      wait_n(6);
      check("R10 snapshot kept", {16'd0, got[15:0]}, 32'h3C81);
   endtask

   task automatic t_idle_ignored;
      int v0;
      logic e0;
      v0 = nvalid;
      e0 = frame_err;
      for (int i = 0; i < 6; i++) begin
         spi_mosi = i[0];
         spi_sck = 1'b1;
         wait_n(4);
         check("R1 hiz with sck", {31'd0, spi_miso}, {31'd0, 1'bz});
         spi_sck = 1'b0;
         wait_n(4);
      end
      check("R1 no strobe", nvalid - v0, 32'd0);
      check("R1 err unchanged", {31'd0, frame_err}, {31'd0, e0});
   endtask

   task automatic t_short;
      logic [31:0] got;
      int v0;
      v0 = nvalid;
      frame(32'h000000A5, 8, 8'hC3, 8'h5A, got);
      check("R7 short err", {31'd0, frame_err}, 32'd1);
      check("R7 no strobe", nvalid - v0, 32'd0);
      check("R4 partial miso", {24'd0, got[7:0]}, 32'h000000C3);
      spi_cs_n = 1'b0;
      wait_n(4);
      check("R7 cleared on select", {31'd0, frame_err}, 32'd0);
      spi_cs_n = 1'b1;
      wait_n(6);
   endtask

   task automatic t_chain;
      logic [31:0] got;
      int v0;
      v0 = nvalid;
      frame(32'h00B4E7D2, 24, 8'h6A, 8'h19, got);
      check("R5 loaded part", {16'd0, got[23:8]}, 32'h00006A19);
      check("R5 mosi echoed", {24'd0, got[7:0]}, 32'h000000B4);
      check("R7 long err", {31'd0, frame_err}, 32'd1);
      check("R7 long no strobe", nvalid - v0, 32'd0);
   endtask

   initial begin
      wait_n(4);
      t_reset();
      rst = 1'b0;
      wait_n(2);
      t_reset();
      t_latency();
      t_word(16'hA55A, 8'h81, 8'h7E);
      t_word(16'h0001, 8'h00, 8'hFF);
      t_word(16'hFFFE, 8'hC4, 8'h02);
      t_din_change();
      t_idle_ignored();
      t_short();
      t_chain();
      t_word(16'h1234, 8'hF0, 8'h0F);
      rst = 1'b1;
      wait_n(2);
      t_reset();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule